// File: doc/BRIEF.md
# JTAG Loader Byte Mailbox

This block is a JTAG data register that carries bytes between an external host and the on-chip loader firmware. Each data-register scan moves a 10-bit word through the register. The word holds two status bits at positions 1:0 and one data byte at positions 9:2. The status bits give the host a busy/valid handshake that the firmware controls. When the host reaches update-DR, three things happen in the same cycle. The byte the host shifted in goes to a receive register the CPU can read. A byte the CPU placed earlier in a holding register is loaded into the shift register, ready for the next scan out. The transmit-ready flag is cleared.

A small programming-control register sits beside the mailbox. It holds an enable bit and a two-bit source select, and the host writes it with its own data-register scan. The mailbox responds only when the enable bit is set and the source select is JTAG. While it responds, the block raises an output that holds the chip's background and debug-mode state machines idle. The TAP controller stays outside this block and supplies instruction and state strobes synchronous to `clk`. The firmware side is reduced to simple register strobes.

Top module: `jtag_loader_mbox`

## Requirements
- R1: After reset, the receive byte, receive-full flag, transmit-ready flag, control register and `tdo` are all 0, and `mbx_active` is 0.
- R2: While the mailbox is selected, each `tap_shift` cycle moves the register one place toward `tdo`, with `tdi` entering at bit 9. `tdo` shows bit 0, so the host sees status bit 0, then status bit 1, then the data byte LSB first.
- R3: On `tap_capture` with the mailbox selected, status bits 1:0 become {1, transmit-ready}. Code 2'b11 means valid data and 2'b10 means busy. Bits 9:2 are left unchanged.
- R4: On `tap_update` with the mailbox selected, `cpu_rx_data` takes bits 9:2 of the shift register, and bits 9:2 are loaded from the holding register. `cpu_rx_data` changes at no other time.
- R5: A mailbox update clears the transmit-ready flag. The clear wins over a `cpu_txc_set` in the same cycle.
- R6: `cpu_txc_set` sets the transmit-ready flag, and `cpu_hold_we` writes `cpu_hold_wdata` into the holding register.
- R7: A mailbox update sets `cpu_rx_full`, and `cpu_rx_rd` clears it. The set wins over a read in the same cycle.
- R8: `mbx_active` is 1 only when control bit 0 (enable) is 1 and bits 2:1 (source) are 2'b00. When it is 0, mailbox capture, shift and update have no effect, and `tdo` is 0 under the mailbox instruction.
- R9: Under instruction `IR_CTL` the 3-bit control register is scanned the same way as the mailbox. Capture loads the current control value, and update writes it. `cpu_ctl_rdata` shows the value with bit 0 as enable and bits 2:1 as source.
- R10: `tap_tlr` clears the control register, and it wins over a control update in the same cycle.
- R11: For any instruction other than `IR_MBX` (default 3'b010) or `IR_CTL` (default 3'b011), `tdo` is 0 and no register changes on TAP strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; TAP strobes are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | IR_W | Current TAP instruction |
| tap_capture | input | 1 | Capture-DR strobe |
| tap_shift | input | 1 | Shift-DR strobe |
| tap_update | input | 1 | Update-DR strobe (falling-edge event) |
| tap_tlr | input | 1 | Test-logic-reset strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cpu_hold_we | input | 1 | Write strobe for the holding register |
| cpu_hold_wdata | input | DATA_W | Byte to send to the host |
| cpu_txc_set | input | 1 | Set the transmit-ready flag |
| cpu_rx_rd | input | 1 | Receive-register read strobe |
| cpu_rx_data | output | DATA_W | Last byte received from the host |
| cpu_rx_full | output | 1 | Unread receive byte present |
| cpu_txc | output | 1 | Transmit-ready flag |
| cpu_ctl_rdata | output | 3 | Control register: {source, enable} |
| mbx_active | output | 1 | Mailbox live; background/debug machines held idle |

## Verification
The assertions check the flag rules on every cycle. Update clears transmit-ready and sets receive-full, with priority over the firmware strobes. The receive byte changes only on a mailbox update, and receive-full cannot rise while the mailbox is inactive. They also check that test-logic-reset clears control and that `tdo` stays quiet under foreign instructions. Only the bench scenarios can show the serial word order and the status codes the host reads. They also show that the byte reaching the host on the next scan is the one the firmware placed in the holding register, and that a UART-mode setting makes a whole scan inert.

// File: rtl/jlm_pkg.sv
package jlm_pkg;
  localparam int STAT_W = 2;
  localparam logic [1:0] SRC_JTAG = 2'b00;

  typedef struct packed {
    logic [1:0] src;
    logic       en;
  } progctl_t;
endpackage

// File: rtl/jlm_shreg.sv
module jlm_shreg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         sh_en,
  input  logic         sin,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_ce;

  always_comb begin
    q_ce  = cap_en | sh_en | ld_en;
    q_nxt = q;
    if (cap_en)     q_nxt = cap_val;
    else if (sh_en) q_nxt = {sin, q[W-1:1]};
    else if (ld_en) q_nxt = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_nxt;
  end
endmodule

// File: rtl/jlm_cpu_regs.sv
module jlm_cpu_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_fire,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              hold_we,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              txc_set,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] hold_q,
  output logic [DATA_W-1:0] rx_q,
  output logic              rx_full_q,
  output logic              txc_q
);
  logic rx_full_nxt, txc_nxt, flag_ce;

  always_comb begin
    txc_nxt     = txc_q;
    rx_full_nxt = rx_full_q;
    if (upd_fire)     txc_nxt = 1'b0;
    else if (txc_set) txc_nxt = 1'b1;
    if (upd_fire)     rx_full_nxt = 1'b1;
    else if (rx_rd)   rx_full_nxt = 1'b0;
    flag_ce = upd_fire | txc_set | rx_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc_q     <= 1'b0;
      rx_full_q <= 1'b0;
    end else if (flag_ce) begin
      txc_q     <= txc_nxt;
      rx_full_q <= rx_full_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_q <= '0;
    else if (upd_fire) rx_q <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_we) hold_q <= hold_wdata;
  end
endmodule

// File: rtl/jlm_progctl.sv
module jlm_progctl
  import jlm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tlr,
  input  logic     upd,
  input  progctl_t upd_val,
  output progctl_t ctl_q
);
  progctl_t ctl_nxt;
  logic     ctl_ce;

  always_comb begin
    ctl_ce  = tlr | upd;
    ctl_nxt = ctl_q;
    if (tlr)      ctl_nxt = '0;
    else if (upd) ctl_nxt = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_ce) ctl_q <= ctl_nxt;
  end
endmodule

// File: rtl/jtag_loader_mbox.sv
module jtag_loader_mbox
  import jlm_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              IR_W   = 3,
  parameter logic [IR_W-1:0] IR_MBX = 3'd2,
  parameter logic [IR_W-1:0] IR_CTL = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              tap_capture,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tap_tlr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              cpu_hold_we,
  input  logic [DATA_W-1:0] cpu_hold_wdata,
  input  logic              cpu_txc_set,
  input  logic              cpu_rx_rd,
  output logic [DATA_W-1:0] cpu_rx_data,
  output logic              cpu_rx_full,
  output logic              cpu_txc,
  output logic [2:0]        cpu_ctl_rdata,
  output logic              mbx_active
);
  localparam int MBX_W = DATA_W + STAT_W;
  localparam int CTL_W = $bits(progctl_t);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  progctl_t          ctl;
  logic              sel_mbx, sel_ctl, mbx_upd;
  logic [MBX_W-1:0]  mq, mbx_cap, mbx_ld;
  logic [CTL_W-1:0]  cq;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    mbx_active = ctl.en && (ctl.src == SRC_JTAG);
    sel_mbx    = (ir_code == IR_MBX) && mbx_active;
    sel_ctl    = (ir_code == IR_CTL);
    mbx_upd    = tap_update && sel_mbx;
    mbx_cap    = {mq[MBX_W-1:STAT_W], 1'b1, cpu_txc};
    mbx_ld     = {hold_q, mq[STAT_W-1:0]};
    if (sel_mbx)      tdo = mq[0];
    else if (sel_ctl) tdo = cq[0];
    else              tdo = 1'b0;
  end

  jlm_shreg #(.W(MBX_W)) u_mbx_sr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_en  (tap_capture && sel_mbx),
    .cap_val (mbx_cap),
    .sh_en   (tap_shift && sel_mbx),
    .sin     (tdi),
    .ld_en   (mbx_upd),
    .ld_val  (mbx_ld),
    .q       (mq)
  );

  jlm_shreg #(.W(CTL_W)) u_ctl_sr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_en  (tap_capture && sel_ctl),
    .cap_val (ctl),
    .sh_en   (tap_shift && sel_ctl),
    .sin     (tdi),
    .ld_en   (1'b0),
    .ld_val  ({CTL_W{1'b0}}),
    .q       (cq)
  );

  jlm_progctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tlr     (tap_tlr),
    .upd     (tap_update && sel_ctl),
    .upd_val (progctl_t'(cq)),
    .ctl_q   (ctl)
  );

  jlm_cpu_regs #(.DATA_W(DATA_W)) u_cpu (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .upd_fire   (mbx_upd),
    .rx_byte    (mq[MBX_W-1:STAT_W]),
    .hold_we    (cpu_hold_we),
    .hold_wdata (cpu_hold_wdata),
    .txc_set    (cpu_txc_set),
    .rx_rd      (cpu_rx_rd),
    .hold_q     (hold_q),
    .rx_q       (cpu_rx_data),
    .rx_full_q  (cpu_rx_full),
    .txc_q      (cpu_txc)
  );

  assign cpu_ctl_rdata = ctl;
endmodule

// File: rtl/jlm_checker.sv
module jlm_checker #(
  parameter int              DATA_W = 8,
  parameter int              IR_W   = 3,
  parameter logic [IR_W-1:0] IR_MBX = 3'd2,
  parameter logic [IR_W-1:0] IR_CTL = 3'd3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IR_W-1:0]   ir_code,
  input logic              tap_update,
  input logic              tap_tlr,
  input logic              cpu_txc_set,
  input logic              cpu_rx_rd,
  input logic              tdo,
  input logic [DATA_W-1:0] cpu_rx_data,
  input logic              cpu_rx_full,
  input logic              cpu_txc,
  input logic [2:0]        cpu_ctl_rdata,
  input logic              mbx_active
);
  logic fire;
  assign fire = tap_update && (ir_code == IR_MBX) && mbx_active;

  a_r5_update_clears_txc: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cpu_txc);
  a_r6_txc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_txc_set && !fire) |=> cpu_txc);
  a_r7_update_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cpu_rx_full);
  a_r7_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rx_rd && !fire) |=> !cpu_rx_full);
  a_r4_rx_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cpu_rx_data));
  a_r8_idle_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !mbx_active |=> !$rose(cpu_rx_full));
  a_r10_tlr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tap_tlr |=> (cpu_ctl_rdata == 3'b000) && !mbx_active);
  a_r11_tdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ir_code != IR_MBX) && (ir_code != IR_CTL)) |-> !tdo);
endmodule

bind jtag_loader_mbox jlm_checker #(
  .DATA_W(DATA_W), .IR_W(IR_W), .IR_MBX(IR_MBX), .IR_CTL(IR_CTL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .ir_code       (ir_code),
  .tap_update    (tap_update),
  .tap_tlr       (tap_tlr),
  .cpu_txc_set   (cpu_txc_set),
  .cpu_rx_rd     (cpu_rx_rd),
  .tdo           (tdo),
  .cpu_rx_data   (cpu_rx_data),
  .cpu_rx_full   (cpu_rx_full),
  .cpu_txc       (cpu_txc),
  .cpu_ctl_rdata (cpu_ctl_rdata),
  .mbx_active    (mbx_active)
);

// File: tb/sim_jtag_loader_mbox.sv
`timescale 1ns/1ps
module sim_jtag_loader_mbox;
  localparam logic [2:0] MBX = 3'd2;
  localparam logic [2:0] CTL = 3'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] ir_code = 3'd0;
  logic tap_capture = 0, tap_shift = 0, tap_update = 0, tap_tlr = 0, tdi = 0;
  logic cpu_hold_we = 0, cpu_txc_set = 0, cpu_rx_rd = 0;
  logic [7:0] cpu_hold_wdata = 8'h00;
  logic tdo, cpu_rx_full, cpu_txc, mbx_active;
  logic [7:0] cpu_rx_data;
  logic [2:0] cpu_ctl_rdata;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  jtag_loader_mbox u0 (
    .clk(clk), .rst_n(rst_n), .ir_code(ir_code), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tap_tlr(tap_tlr), .tdi(tdi),
    .tdo(tdo), .cpu_hold_we(cpu_hold_we), .cpu_hold_wdata(cpu_hold_wdata),
    .cpu_txc_set(cpu_txc_set), .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data),
    .cpu_rx_full(cpu_rx_full), .cpu_txc(cpu_txc), .cpu_ctl_rdata(cpu_ctl_rdata),
    .mbx_active(mbx_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, compared every clock before it advances
  int m_en, m_src, m_hold, m_rx, m_rxf, m_txc;
  bit m_sr[10];
  bit m_cs[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_src = 0; m_hold = 0; m_rx = 0; m_rxf = 0; m_txc = 0;
      foreach (m_sr[i]) m_sr[i] = 0;
      foreach (m_cs[i]) m_cs[i] = 0;
    end else begin
      int act, smb, sct, etdo, fire, byte_in;
      act  = (m_en == 1 && m_src == 0);
      smb  = (ir_code == MBX) && act;
      sct  = (ir_code == CTL);
      etdo = smb ? m_sr[0] : (sct ? m_cs[0] : 0);
      chk("R2 model tdo", tdo, etdo);
      chk("R4 model rx_data", cpu_rx_data, m_rx);
      chk("R7 model rx_full", cpu_rx_full, m_rxf);
      chk("R5 model txc", cpu_txc, m_txc);
      chk("R8 model active", mbx_active, act);
      chk("R9 model ctl", cpu_ctl_rdata, m_src * 2 + m_en);
      fire = tap_update && smb;
      if (tap_tlr) begin m_en = 0; m_src = 0; end
      else if (tap_update && sct) begin m_en = m_cs[0]; m_src = m_cs[1] + 2 * m_cs[2]; end
      if (tap_capture && sct) begin
        m_cs[0] = bit'(m_en); m_cs[1] = bit'(m_src % 2); m_cs[2] = bit'(m_src / 2);
      end else if (tap_shift && sct) begin
        m_cs[0] = m_cs[1]; m_cs[1] = m_cs[2]; m_cs[2] = tdi;
      end
      if (tap_capture && smb) begin
        m_sr[0] = bit'(m_txc); m_sr[1] = 1;
      end else if (tap_shift && smb) begin
        for (int i = 0; i < 9; i++) m_sr[i] = m_sr[i+1];
        m_sr[9] = tdi;
      end else if (fire) begin
        byte_in = 0;
        for (int i = 0; i < 8; i++) byte_in += int'(m_sr[i+2]) << i;
        m_rx = byte_in;
        for (int i = 0; i < 8; i++) m_sr[i+2] = bit'((m_hold >> i) & 1);
      end
      if (fire) m_txc = 0; else if (cpu_txc_set) m_txc = 1;
      if (fire) m_rxf = 1; else if (cpu_rx_rd) m_rxf = 0;
      if (cpu_hold_we) m_hold = cpu_hold_wdata;
    end
  end

  // extra: 0 none, 1 txc_set during update, 2 rx_rd during update
  task automatic scan(input logic [2:0] ir, input int n, input int win, input int extra,
                      output int wout);
    wout = 0;
    @(negedge clk); ir_code = ir; tap_capture = 1;
    @(negedge clk); tap_capture = 0;
    for (int i = 0; i < n; i++) begin
      wout |= int'(tdo) << i;
      tdi = bit'((win >> i) & 1); tap_shift = 1;
      @(negedge clk);
      tap_shift = 0;
    end
    tdi = 0; tap_update = 1;
    cpu_txc_set = (extra == 1); cpu_rx_rd = (extra == 2);
    @(negedge clk); tap_update = 0; cpu_txc_set = 0; cpu_rx_rd = 0;
  endtask

  task automatic cpu_put(input logic [7:0] b, input logic set);
    @(negedge clk); cpu_hold_we = 1; cpu_hold_wdata = b; cpu_txc_set = set;
    @(negedge clk); cpu_hold_we = 0; cpu_txc_set = 0;
  endtask

  task automatic cpu_read();
    @(negedge clk); cpu_rx_rd = 1;
    @(negedge clk); cpu_rx_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 rx_data", cpu_rx_data, 0);
    chk("R1 rx_full", cpu_rx_full, 0);
    chk("R1 txc", cpu_txc, 0);
    chk("R1 ctl", cpu_ctl_rdata, 0);
    chk("R1 active", mbx_active, 0);
    chk("R1 tdo", tdo, 0);

    scan(CTL, 3, 3'b001, 0, w);
    chk("R9 ctl capture", w, 0);
    chk("R9 ctl write", cpu_ctl_rdata, 3'b001);
    chk("R8 active jtag", mbx_active, 1);
    scan(CTL, 3, 3'b001, 0, w);
    chk("R9 ctl readback", w, 3'b001);

    cpu_put(8'hA5, 1);
    chk("R6 txc set", cpu_txc, 1);
    scan(MBX, 10, {8'h3C, 2'b00}, 0, w);
    chk("R3 valid status word", w, 10'h003);
    chk("R4 rx byte", cpu_rx_data, 8'h3C);
    chk("R7 full on update", cpu_rx_full, 1);
    chk("R5 txc cleared", cpu_txc, 0);
    cpu_read();
    chk("R7 read clears", cpu_rx_full, 0);
    scan(MBX, 10, {8'h5A, 2'b01}, 0, w);
    chk("R2 busy + hold byte", w, {8'hA5, 2'b10});
    chk("R4 second rx", cpu_rx_data, 8'h5A);

    cpu_put(8'h81, 0);
    scan(MBX, 10, {8'hC3, 2'b11}, 1, w);
    chk("R5 clear beats set", cpu_txc, 0);
    chk("R2 third word", w, {8'hA5, 2'b10});
    scan(MBX, 10, {8'h11, 2'b00}, 2, w);
    chk("R7 set beats read", cpu_rx_full, 1);
    chk("R4 hold reaches host", w, {8'h81, 2'b10});

    cpu_put(8'h77, 1);
    scan(3'd0, 10, 10'h3FF, 0, w);
    chk("R11 foreign ir tdo", w, 0);
    chk("R11 foreign ir rx", cpu_rx_data, 8'h11);
    chk("R11 foreign ir txc", cpu_txc, 1);

    scan(CTL, 3, 3'b011, 0, w);
    chk("R8 uart inactive", mbx_active, 0);
    scan(MBX, 10, 10'h2AA, 0, w);
    chk("R8 uart tdo", w, 0);
    chk("R8 uart rx", cpu_rx_data, 8'h11);
    chk("R8 uart txc kept", cpu_txc, 1);
    scan(CTL, 3, 3'b000, 0, w);
    chk("R8 disabled inactive", mbx_active, 0);

    scan(CTL, 3, 3'b001, 0, w);
    @(negedge clk); tap_tlr = 1;
    @(negedge clk); tap_tlr = 0;
    chk("R10 tlr ctl", cpu_ctl_rdata, 0);
    chk("R10 tlr active", mbx_active, 0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule